// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores the single-precision registers of a floating-point unit: 64 words of 32 bits that one 32-bit FP control register steers. Three bits of that register pick the active bank, the width of move transfers and the precision of mixed-format accesses. Callers address a register by a 6-bit logical index and an access kind. The kind says whether the access is to one word or to an aligned pair of words read as one 64-bit double, and whether it goes to the active bank or the inactive one. A bank shifts the logical index by 16 words, modulo 64.

There is one combinational read port and one write port, and both decode their index in the same way. Format conversion is not done here. When an access needs a single value widened or a double value narrowed, the raw 32-bit word moves in the low half of the 64-bit data bus and a conversion-request flag asks the downstream unit to do the conversion. Illegal requests are flagged and have no effect.

The block has no state machine. Storage and the control register are plain registers with a synchronous, active-low reset, and all decoding is combinational.

Top module: `fpbank_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 64 words and the control register become zero.
- R2: In the control register, bit 21 is the bank bit, bit 20 is the move-size bit and bit 19 is the precision bit. `ctl_we` loads all 32 bits. `fld_we[k]` loads `fld_val[k]` into a single field, where k=0 is precision, k=1 is size and k=2 is bank, and no other bit changes. When both strobes are active in the same cycle, the field writes take precedence over the full load.
- R3: Kind 0 (active single) reaches physical word (idx + 16·bank) mod 64.
- R4: Kind 1 (inactive single) reaches physical word (idx + 16·(1−bank)) mod 64.
- R5: Kind 2 (active double) uses the even base b = (idx + 16·bank) mod 64. A read returns {word b, word b+1}, with word b in bits 63:32. A write stores bits 63:32 into word b and bits 31:0 into word b+1, both at the same edge.
- R6: Kind 3 (inactive double) works like R5, with base (idx + 16·(1−bank)) mod 64.
- R7: Kind 4 (mixed): when the precision bit is 1, it behaves as kind 2. When the precision bit is 0, it reaches the active single. A read then returns the word zero-extended in bits 31:0 with `rd_cvt` high, and a write stores `wr_data[31:0]` with `wr_cvt` high.
- R8: Kind 5 (move): when the size bit is 0, it reaches the active single with the conversion flag high. When the size bit is 1 and idx is even, it reaches the active double at idx. When the size bit is 1 and idx is odd, it reaches the inactive double at idx with bit 0 cleared. Odd indices are legal for this kind.
- R9: A request is illegal when its index is odd on kind 2, on kind 3 or on kind 4 with precision 1, or when its kind is 6 or 7. An illegal read returns all zeros with `rd_illegal` high. An illegal write leaves every word unchanged and raises `wr_illegal`.
- R10: A write decodes with the control value held before the edge, even if the control register changes at that same edge. Reads are combinational, so data written at an edge is visible on `rd_data` after that edge.
- R11: `rd_wide`/`wr_wide` are high exactly when a legal request moves a 64-bit pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Load whole control register |
| ctl_wdata | input | 32 | Control register load value |
| fld_we | input | 3 | Per-field write strobes (0 precision, 1 size, 2 bank) |
| fld_val | input | 3 | Per-field write values |
| ctl_q | output | 32 | Current control register |
| rd_kind | input | 3 | Read access kind |
| rd_idx | input | 6 | Read logical index |
| rd_data | output | 64 | Read data |
| rd_wide | output | 1 | Read returns a register pair |
| rd_cvt | output | 1 | Read needs widening downstream |
| rd_illegal | output | 1 | Read request illegal |
| wr_en | input | 1 | Write request |
| wr_kind | input | 3 | Write access kind |
| wr_idx | input | 6 | Write logical index |
| wr_data | input | 64 | Write data |
| wr_wide | output | 1 | Write stores a register pair |
| wr_cvt | output | 1 | Write value was narrowed upstream |
| wr_illegal | output | 1 | Write request illegal, ignored |

## Verification
The bench builds the block with its defaults: 64 words and a bank stride of 16. With these values the modulo wrap of the bank offset is exercised, because the upper banks reach back to words 0 to 15, and every word can be reached through the active single kind with the bank bit at 0. Random traffic with a fixed seed mixes control-field writes with accesses of every kind and index, including the reserved kinds and odd double indices. Directed cycles cover the state after reset, a field write colliding with a full load, and a write landing in the same cycle as a bank change.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;

    typedef enum logic [2:0] {
        KIND_CUR_SGL = 3'd0,
        KIND_OTH_SGL = 3'd1,
        KIND_CUR_DBL = 3'd2,
        KIND_OTH_DBL = 3'd3,
        KIND_MIXED   = 3'd4,
        KIND_MOVE    = 3'd5,
        KIND_RSV6    = 3'd6,
        KIND_RSV7    = 3'd7
    } acc_kind_e;

    localparam int CTL_W     = 32;
    localparam int NFIELDS   = 3;
    localparam int PREC_POS  = 19;
    localparam int SIZE_POS  = 20;
    localparam int BANK_POS  = 21;

    function automatic int field_pos(input int k);
        case (k)
            0:       return PREC_POS;
            1:       return SIZE_POS;
            default: return BANK_POS;
        endcase
    endfunction

endpackage

// File: rtl/fpbank_ctl.sv
module fpbank_ctl
    import fpbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [CTL_W-1:0]     ctl_wdata,
    input  logic [NFIELDS-1:0]   fld_we,
    input  logic [NFIELDS-1:0]   fld_val,
    output logic [CTL_W-1:0]     ctl_q
);

    logic [CTL_W-1:0] ctl_next;

    always_comb begin
        ctl_next = ctl_we ? ctl_wdata : ctl_q;
        for (int k = 0; k < NFIELDS; k++) begin
            if (fld_we[k]) begin
                ctl_next[field_pos(k)] = fld_val[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_next;
        end
    end

    // R2: a lone bank-field write leaves every other bit alone
    p_bank_only_keeps_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we == 3'b100 && !ctl_we) |=>
            (ctl_q[31:22] == $past(ctl_q[31:22]) && ctl_q[20:0] == $past(ctl_q[20:0])));

    // R2: a field write wins over a same-cycle full load
    p_field_over_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && fld_we[0]) |=> (ctl_q[PREC_POS] == $past(fld_val[0])));

endmodule

// File: rtl/fpbank_decode.sv
module fpbank_decode
    import fpbank_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int STRIDE = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic [2:0]    kind,
    input  logic [AW-1:0] idx,
    input  logic          bank,
    input  logic          size,
    input  logic          prec,
    output logic [AW-1:0] base,
    output logic          wide,
    output logic          cvt,
    output logic          illegal
);

    logic [AW-1:0] cur_off;
    logic [AW-1:0] oth_off;
    logic [AW-1:0] cur_phys;
    logic [AW-1:0] oth_phys;
    logic [AW-1:0] oth_even;
    logic [AW-1:0] idx_even;

    always_comb begin
        cur_off  = bank ? AW'(STRIDE) : '0;
        oth_off  = bank ? '0 : AW'(STRIDE);
        idx_even = {idx[AW-1:1], 1'b0};
        cur_phys = idx + cur_off;
        oth_phys = idx + oth_off;
        oth_even = idx_even + oth_off;
    end

    always_comb begin
        base    = cur_phys;
        wide    = 1'b0;
        cvt     = 1'b0;
        illegal = 1'b0;
        unique case (acc_kind_e'(kind))
            KIND_CUR_SGL: base = cur_phys;
            KIND_OTH_SGL: base = oth_phys;
            KIND_CUR_DBL: begin
                wide    = 1'b1;
                illegal = idx[0];
            end
            KIND_OTH_DBL: begin
                base    = oth_phys;
                wide    = 1'b1;
                illegal = idx[0];
            end
            KIND_MIXED: begin
                if (prec) begin
                    wide    = 1'b1;
                    illegal = idx[0];
                end else begin
                    cvt = 1'b1;
                end
            end
            KIND_MOVE: begin
                if (!size) begin
                    cvt = 1'b1;
                end else if (idx[0]) begin
                    base = oth_even;
                    wide = 1'b1;
                end else begin
                    wide = 1'b1;
                end
            end
            KIND_RSV6, KIND_RSV7: illegal = 1'b1;
        endcase
        if (illegal) begin
            wide = 1'b0;
            cvt  = 1'b0;
        end
    end

endmodule

// File: rtl/fpbank_store.sv
module fpbank_store #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       rbase,
    output logic [WORD_W-1:0]   rd_hi,
    output logic [WORD_W-1:0]   rd_lo,
    input  logic                we,
    input  logic                wwide,
    input  logic [AW-1:0]       wbase,
    input  logic [2*WORD_W-1:0] wdata
);

    logic [WORD_W-1:0] mem [WORDS];
    logic [AW-1:0]     rbase_nx;
    logic [AW-1:0]     wbase_nx;
    logic [WORD_W-1:0] hi_val;

    assign rbase_nx = rbase + AW'(1);
    assign wbase_nx = wbase + AW'(1);
    assign rd_hi    = mem[rbase];
    assign rd_lo    = mem[rbase_nx];
    assign hi_val   = wwide ? wdata[2*WORD_W-1:WORD_W] : wdata[WORD_W-1:0];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic hit_hi;
        logic hit_lo;
        assign hit_hi = we && (wbase == AW'(g));
        assign hit_lo = we && wwide && (wbase_nx == AW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hit_hi) begin
                mem[g] <= hi_val;
            end else if (hit_lo) begin
                mem[g] <= wdata[WORD_W-1:0];
            end
        end
    end

    // R5: a pair write lands both halves at one edge
    p_pair_same_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wwide) |=>
            (mem[$past(wbase)] == $past(wdata[2*WORD_W-1:WORD_W]) &&
             mem[$past(wbase_nx)] == $past(wdata[WORD_W-1:0])));

endmodule

// File: rtl/fpbank_regfile.sv
module fpbank_regfile
    import fpbank_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WORD_W = 32,
    parameter int STRIDE = 16,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = 2 * WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [31:0]     ctl_wdata,
    input  logic [2:0]      fld_we,
    input  logic [2:0]      fld_val,
    output logic [31:0]     ctl_q,
    input  logic [2:0]      rd_kind,
    input  logic [AW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            rd_wide,
    output logic            rd_cvt,
    output logic            rd_illegal,
    input  logic            wr_en,
    input  logic [2:0]      wr_kind,
    input  logic [AW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_wide,
    output logic            wr_cvt,
    output logic            wr_illegal
);

    logic [AW-1:0]     rd_base;
    logic [AW-1:0]     wr_base;
    logic [WORD_W-1:0] word_hi;
    logic [WORD_W-1:0] word_lo;
    logic              store_we;

    fpbank_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .fld_we    (fld_we),
        .fld_val   (fld_val),
        .ctl_q     (ctl_q)
    );

    fpbank_decode #(.WORDS(WORDS), .STRIDE(STRIDE)) u_rd_dec (
        .kind    (rd_kind),
        .idx     (rd_idx),
        .bank    (ctl_q[BANK_POS]),
        .size    (ctl_q[SIZE_POS]),
        .prec    (ctl_q[PREC_POS]),
        .base    (rd_base),
        .wide    (rd_wide),
        .cvt     (rd_cvt),
        .illegal (rd_illegal)
    );

    fpbank_decode #(.WORDS(WORDS), .STRIDE(STRIDE)) u_wr_dec (
        .kind    (wr_kind),
        .idx     (wr_idx),
        .bank    (ctl_q[BANK_POS]),
        .size    (ctl_q[SIZE_POS]),
        .prec    (ctl_q[PREC_POS]),
        .base    (wr_base),
        .wide    (wr_wide),
        .cvt     (wr_cvt),
        .illegal (wr_illegal)
    );

    assign store_we = wr_en && !wr_illegal;

    fpbank_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .rbase (rd_base),
        .rd_hi (word_hi),
        .rd_lo (word_lo),
        .we    (store_we),
        .wwide (wr_wide),
        .wbase (wr_base),
        .wdata (wr_data)
    );

    always_comb begin
        if (rd_illegal) begin
            rd_data = '0;
        end else if (rd_wide) begin
            rd_data = {word_hi, word_lo};
        end else begin
            rd_data = {{WORD_W{1'b0}}, word_hi};
        end
    end

    // R7: a read that asks for widening carries nothing in the upper half
    p_cvt_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cvt |-> (rd_data[DW-1:WORD_W] == '0));

    // R9: an illegal pair request always comes from an odd index
    p_illegal_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_illegal && (wr_kind == 3'd2 || wr_kind == 3'd3)) |-> wr_idx[0]);

    // R8: a legal move with the size bit set transfers a pair
    p_move_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == 3'd5 && ctl_q[SIZE_POS] && !rd_illegal) |-> rd_wide);

    // R11: no request is both wide and in need of conversion
    p_wide_cvt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_wide && rd_cvt));

endmodule

// File: tb/fpbank_regfile_bench.sv
module fpbank_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic [2:0]  fld_we;
    logic [2:0]  fld_val;
    logic [31:0] ctl_q;
    logic [2:0]  rd_kind;
    logic [5:0]  rd_idx;
    logic [63:0] rd_data;
    logic        rd_wide, rd_cvt, rd_illegal;
    logic        wr_en;
    logic [2:0]  wr_kind;
    logic [5:0]  wr_idx;
    logic [63:0] wr_data;
    logic        wr_wide, wr_cvt, wr_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_mem [WORDS];
    logic [31:0] exp_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpbank_regfile u_fpbank_regfile (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fld_we(fld_we), .fld_val(fld_val), .ctl_q(ctl_q),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_wide(rd_wide), .rd_cvt(rd_cvt), .rd_illegal(rd_illegal),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_wide(wr_wide), .wr_cvt(wr_cvt), .wr_illegal(wr_illegal)
    );

    // Bench-side decode, written from the requirements
    function automatic void model_dec(input logic [2:0] kind, input logic [5:0] idx,
                                      input logic [31:0] ctl,
                                      output logic [5:0] base, output logic wide,
                                      output logic cvt, output logic ill);
        logic bk, sz, pr;
        logic [5:0] cur, oth;
        bk = ctl[21]; sz = ctl[20]; pr = ctl[19];
        cur = 6'((int'(idx) + (bk ? 16 : 0)) % 64);
        oth = 6'((int'(idx) + (bk ? 0 : 16)) % 64);
        base = cur; wide = 0; cvt = 0; ill = 0;
        case (kind)
            3'd0: base = cur;
            3'd1: base = oth;
            3'd2: begin wide = 1; ill = idx[0]; end
            3'd3: begin base = oth; wide = 1; ill = idx[0]; end
            3'd4: if (pr) begin wide = 1; ill = idx[0]; end else cvt = 1;
            3'd5: if (!sz) cvt = 1;
                  else if (idx[0]) begin
                      base = 6'((int'(idx) - 1 + (bk ? 0 : 16)) % 64); wide = 1;
                  end else wide = 1;
            default: ill = 1;
        endcase
        if (ill) begin wide = 0; cvt = 0; end
    endfunction

    function automatic string req_of(input logic [2:0] kind, input logic ill);
        if (ill) return "R9";
        case (kind)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Inputs already driven (away from the edge); check, then clock and update the model
    task automatic run_cycle(input string tag);
        logic [5:0] b; logic w, c, il;
        logic [63:0] exp_rd;
        logic [31:0] nctl;
        #1;
        model_dec(rd_kind, rd_idx, exp_ctl, b, w, c, il);
        if (il) exp_rd = '0;
        else if (w) exp_rd = {exp_mem[b], exp_mem[6'(b + 6'd1)]};
        else exp_rd = {32'd0, exp_mem[b]};
        check({req_of(rd_kind, il), tag}, "rd_data", rd_data, exp_rd);
        check({req_of(rd_kind, il), tag}, "rd_flags", {61'd0, rd_wide, rd_cvt, rd_illegal},
              {61'd0, w, c, il});
        model_dec(wr_kind, wr_idx, exp_ctl, b, w, c, il);
        check({"R11", tag}, "wr_flags", {61'd0, wr_wide, wr_cvt, wr_illegal},
              {61'd0, w, c, il});
        check({"R2", tag}, "ctl_q", ctl_q, exp_ctl);
        @(posedge clk);
        if (wr_en && !il) begin
            if (w) begin
                exp_mem[b] = wr_data[63:32];
                exp_mem[6'(b + 6'd1)] = wr_data[31:0];
            end else begin
                exp_mem[b] = wr_data[31:0];
            end
        end
        nctl = ctl_we ? ctl_wdata : exp_ctl;
        if (fld_we[0]) nctl[19] = fld_val[0];
        if (fld_we[1]) nctl[20] = fld_val[1];
        if (fld_we[2]) nctl[21] = fld_val[2];
        exp_ctl = nctl;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ctl_we = 0; ctl_wdata = '0; fld_we = '0; fld_val = '0;
        rd_kind = '0; rd_idx = '0; wr_en = 0; wr_kind = '0; wr_idx = '0; wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        wr_en = 1; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        ctl_we = 1; ctl_wdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_inputs();
        rst_n = 1;
        for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
        exp_ctl = '0;

        // R1: every word and the control register read zero after reset
        for (int i = 0; i < WORDS; i++) begin
            rd_kind = 3'd0; rd_idx = 6'(i);
            #1;
            check("R1", "reset word", rd_data, 64'd0);
            @(negedge clk);
        end
        check("R1", "reset ctl", ctl_q, 64'd0);

        // R2: full load and a colliding field write
        ctl_we = 1; ctl_wdata = 32'hFFFF_FFFF; fld_we = 3'b100; fld_val = 3'b000;
        run_cycle("_collide");
        idle_inputs();
        fld_we = 3'b001; fld_val = 3'b000;
        run_cycle("_field");
        idle_inputs();
        ctl_we = 1; ctl_wdata = 32'h0;
        run_cycle("_clear");
        idle_inputs();

        // R5 / R6: pair write in bank 0, read back from both banks
        wr_en = 1; wr_kind = 3'd2; wr_idx = 6'd4; wr_data = 64'h1111_2222_3333_4444;
        run_cycle("_pairw");
        idle_inputs();
        rd_kind = 3'd2; rd_idx = 6'd4; run_cycle("_pairr");
        fld_we = 3'b100; fld_val = 3'b100; run_cycle("_bank1");
        idle_inputs();
        rd_kind = 3'd3; rd_idx = 6'd4; run_cycle("_othr");
        rd_kind = 3'd0; rd_idx = 6'd50; run_cycle("_wrap");

        // R10: write lands with the old bank while the bank flips
        wr_en = 1; wr_kind = 3'd0; wr_idx = 6'd1; wr_data = 64'hDEAD_BEEF;
        fld_we = 3'b100; fld_val = 3'b000;
        run_cycle("_r10w");
        idle_inputs();
        rd_kind = 3'd1; rd_idx = 6'd1; run_cycle("_r10r");

        // R9: odd index pair write is ignored
        wr_en = 1; wr_kind = 3'd2; wr_idx = 6'd5; wr_data = 64'hAAAA_AAAA_BBBB_BBBB;
        run_cycle("_odd");
        idle_inputs();
        rd_kind = 3'd0; rd_idx = 6'd5; run_cycle("_oddr");

        // R8: move with size set, odd index goes to the other bank
        fld_we = 3'b010; fld_val = 3'b010; run_cycle("_sz");
        idle_inputs();
        rd_kind = 3'd5; rd_idx = 6'd5; run_cycle("_mvodd");
        rd_kind = 3'd5; rd_idx = 6'd4; run_cycle("_mveven");

        // Constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            ctl_we    = ($urandom % 16) == 0;
            ctl_wdata = $urandom;
            fld_we    = 3'($urandom % 8) & {3{($urandom % 4) == 0}};
            fld_val   = 3'($urandom % 8);
            rd_kind   = 3'($urandom % 8);
            rd_idx    = 6'($urandom % 64);
            wr_en     = $urandom % 2;
            wr_kind   = 3'($urandom % 8);
            wr_idx    = 6'($urandom % 64);
            wr_data   = {$urandom, $urandom};
            run_cycle("_rand");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule